// File: doc/BRIEF.md
# Dual-Lane Unsigned Fractional Half-Word Multiplier

This execution unit keeps a small file of 32-bit registers. Each register is treated as two 16-bit halves. A load port writes a whole 32-bit word into any register. A multiply command names a destination register and carries two independent lanes, a high lane and a low lane.

Each lane selects two 16-bit operands. Every operand may be either half of any register. The lane multiplies the two operands as unsigned fractions and keeps only the upper 16 bits of the 32-bit product, with no rounding. The two lane results are then packed into the destination in a single write: the high-lane result goes to bits 31..16 and the low-lane result to bits 15..0.

The operands are read before the write happens, so a command may use its own destination as a source. An asynchronous read port returns the contents of any register.

Top module: `fhmul_unit`

## Requirements
- R1: Each lane result is bits [31:16] of the unsigned 32-bit product of its two 16-bit operands, and the low 16 bits of the product are dropped. Examples: 0x5625×0x5625 gives 0x1CFC, 0x5625×0x5127 gives 0x1B4E, and 0x98BA×0x98BA gives 0x5B1D.
- R2: Operands are unsigned even when bit 15 is set. Examples: 0x800E×0x800E gives 0x400E, 0xE06D×0xE06D gives 0xC4BE, and 0xFFFF×0xFFFF gives 0xFFFE.
- R3: A multiply accepted with mul_valid high writes {high-lane result, low-lane result} into register mul_dst at the next rising clock edge.
- R4: Each of the four operand selections picks its register with its own 3-bit index and its half with its own flag (1 = bits 31..16, 0 = bits 15..0). Each selection is independent of the other three.
- R5: A lane whose product is below 0x10000 writes zero to its half. Example: 0x000C×0x0007 gives 0x0000. A zero operand also gives zero.
- R6: Both lanes read their operands before the write. A command may name its own destination as a source, and the next command sees the updated value.
- R7: With ld_en high, ld_word is written into register ld_sel at the next rising edge, unless a multiply targets the same register in that cycle.
- R8: When a load and a multiply target the same register in the same cycle, the multiply result is written.
- R9: A synchronous active-low reset (rst_n = 0 at a rising edge) clears all eight registers to zero.
- R10: rd_word combinationally shows the current contents of register rd_idx, with no clock edge needed.
- R11: In a cycle with neither ld_en nor mul_valid high, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Register index for the load |
| ld_word | input | 32 | Word to load |
| mul_valid | input | 1 | Multiply command strobe |
| mul_dst | input | 3 | Destination register of the multiply |
| hi_a_idx | input | 3 | High lane, operand A register |
| hi_a_upper | input | 1 | High lane, operand A half (1 = upper) |
| hi_b_idx | input | 3 | High lane, operand B register |
| hi_b_upper | input | 1 | High lane, operand B half (1 = upper) |
| lo_a_idx | input | 3 | Low lane, operand A register |
| lo_a_upper | input | 1 | Low lane, operand A half (1 = upper) |
| lo_b_idx | input | 3 | Low lane, operand B register |
| lo_b_upper | input | 1 | Low lane, operand B half (1 = upper) |
| rd_idx | input | 3 | Read port register index |
| rd_word | output | 32 | Contents of register rd_idx |

## Verification
Fixed vectors with mid-range operands show that the upper product half is kept and not the lower half or a shifted value. Operands with bit 15 set, up to 0xFFFF×0xFFFF, separate unsigned from signed handling. A sweep that rotates all four operand selections across different registers and halves, checked against a model kept in the bench, exposes any swapped lane, swapped half or shared selector. Chained commands that name their own destination, tiny products, a load and a multiply on the same register, and idle cycles cover the ordering, zero, priority and hold cases.

// File: rtl/fhmul_pkg.sv
// fhmul_pkg: shared sizing constants for the dual-lane fractional multiplier.
// Assumes a register word is an even number of bits, split into two halves.
package fhmul_pkg;
    localparam int FHM_NREG  = 8;
    localparam int FHM_WORD  = 32;
    localparam int FHM_LANES = 2;
    localparam int FHM_LANE_HI = 1;
    localparam int FHM_LANE_LO = 0;
endpackage

// File: rtl/fhmul_regfile.sv
// fhmul_regfile: register file with one load write port and one multiply
// write port. Every entry is visible at once on rf_view.
// Assumes: multiply write wins over load write on the same entry; reset is
// synchronous and active-low.
module fhmul_regfile #(
    parameter int NREG = 8,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mul_we,
    input  logic [AW-1:0]            mul_addr,
    input  logic [W-1:0]             mul_data,
    input  logic                     ld_we,
    input  logic [AW-1:0]            ld_addr,
    input  logic [W-1:0]             ld_data,
    output logic [NREG-1:0][W-1:0]   rf_view
);
    for (genvar i = 0; i < NREG; i++) begin : g_ent
        localparam logic [AW-1:0] IDX = AW'(i);
        logic [W-1:0] q;
        logic         hit_mul;
        logic         hit_ld;

        // decode which write port addresses this entry
        always_comb begin
            hit_mul = mul_we && (mul_addr == IDX);
            hit_ld  = ld_we  && (ld_addr  == IDX);
        end

        // entry storage: reset, then multiply over load priority
        always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (hit_mul) q <= mul_data;
            else if (hit_ld)  q <= ld_data;
        end

        assign rf_view[i] = q;
    end
endmodule

// File: rtl/fhmul_lane.sv
// fhmul_lane: one multiply lane. Picks a half of each of two source words,
// multiplies them unsigned, and returns the upper half of the product
// (truncated, no rounding). Purely combinational.
// Assumes W is even; halves are H = W/2 bits wide.
module fhmul_lane #(
    parameter int W = 32,
    localparam int H = W / 2
) (
    input  logic [W-1:0] a_word,
    input  logic         a_upper,
    input  logic [W-1:0] b_word,
    input  logic         b_upper,
    output logic [H-1:0] a_half,
    output logic [H-1:0] b_half,
    output logic [H-1:0] res
);
    logic [W-1:0] prod;

    // half selection for both operands
    always_comb begin
        a_half = a_upper ? a_word[W-1:H] : a_word[H-1:0];
        b_half = b_upper ? b_word[W-1:H] : b_word[H-1:0];
    end

    // unsigned product, keep the top half
    always_comb begin
        prod = W'(a_half) * W'(b_half);
        res  = prod[W-1:H];
    end
endmodule

// File: rtl/fhmul_unit.sv
// fhmul_unit: top of the dual-lane unsigned fractional multiplier.
// Fetches four operands from the register file, runs a high and a low lane,
// and writes the packed result into the destination at the next clock edge.
// A load port and an asynchronous read port complete the unit.
// Assumes: the lanes read pre-write register contents; multiply beats load.
module fhmul_unit
    import fhmul_pkg::*;
#(
    parameter int NREG = FHM_NREG,
    parameter int W    = FHM_WORD,
    localparam int AW  = $clog2(NREG),
    localparam int H   = W / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_sel,
    input  logic [W-1:0]  ld_word,
    input  logic          mul_valid,
    input  logic [AW-1:0] mul_dst,
    input  logic [AW-1:0] hi_a_idx,
    input  logic          hi_a_upper,
    input  logic [AW-1:0] hi_b_idx,
    input  logic          hi_b_upper,
    input  logic [AW-1:0] lo_a_idx,
    input  logic          lo_a_upper,
    input  logic [AW-1:0] lo_b_idx,
    input  logic          lo_b_upper,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_word
);
    logic [NREG-1:0][W-1:0] rf_view;
    logic [AW-1:0] a_idx [FHM_LANES];
    logic          a_up  [FHM_LANES];
    logic [AW-1:0] b_idx [FHM_LANES];
    logic          b_up  [FHM_LANES];
    logic [H-1:0]  opa_v [FHM_LANES];
    logic [H-1:0]  opb_v [FHM_LANES];
    logic [H-1:0]  lres  [FHM_LANES];
    logic [W-1:0]  mul_data;

    // gather the per-lane selectors into lane-indexed arrays
    always_comb begin
        a_idx[FHM_LANE_HI] = hi_a_idx;
        a_up [FHM_LANE_HI] = hi_a_upper;
        b_idx[FHM_LANE_HI] = hi_b_idx;
        b_up [FHM_LANE_HI] = hi_b_upper;
        a_idx[FHM_LANE_LO] = lo_a_idx;
        a_up [FHM_LANE_LO] = lo_a_upper;
        b_idx[FHM_LANE_LO] = lo_b_idx;
        b_up [FHM_LANE_LO] = lo_b_upper;
    end

    for (genvar l = 0; l < FHM_LANES; l++) begin : g_lane
        fhmul_lane #(.W(W)) u_lane (
            .a_word (rf_view[a_idx[l]]),
            .a_upper(a_up[l]),
            .b_word (rf_view[b_idx[l]]),
            .b_upper(b_up[l]),
            .a_half (opa_v[l]),
            .b_half (opb_v[l]),
            .res    (lres[l])
        );
    end

    // pack high lane above low lane
    always_comb mul_data = {lres[FHM_LANE_HI], lres[FHM_LANE_LO]};

    fhmul_regfile #(.NREG(NREG), .W(W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .mul_we  (mul_valid),
        .mul_addr(mul_dst),
        .mul_data(mul_data),
        .ld_we   (ld_en),
        .ld_addr (ld_sel),
        .ld_data (ld_word),
        .rf_view (rf_view)
    );

    // asynchronous read port
    always_comb rd_word = rf_view[rd_idx];
endmodule

// File: rtl/fhmul_chk.sv
// fhmul_chk: property checker for fhmul_unit, attached by bind below.
// Observes the command ports, the lane operands/results and the register view.
module fhmul_chk #(
    parameter int NREG = 8,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG),
    localparam int H   = W / 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ld_en,
    input logic [AW-1:0]          ld_sel,
    input logic [W-1:0]           ld_word,
    input logic                   mul_valid,
    input logic [AW-1:0]          mul_dst,
    input logic [H-1:0]           hi_a,
    input logic [H-1:0]           hi_b,
    input logic [H-1:0]           hi_r,
    input logic [H-1:0]           lo_a,
    input logic [H-1:0]           lo_b,
    input logic [H-1:0]           lo_r,
    input logic [NREG-1:0][W-1:0] rf_view
);
    // R1
    hi_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_a != '0) |-> (hi_r < hi_a));
    // R1
    lo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_b != '0) |-> (lo_r < lo_b));
    // R2
    hi_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_a[H-1] && hi_b[H-1]) |-> (hi_r[H-1:H-2] != 2'b00));
    // R5
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_a == '0) || (lo_b == '0)) |-> (lo_r == '0));
    // R3
    mul_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_valid |=> (rf_view[$past(mul_dst)] == {$past(hi_r), $past(lo_r)}));
    // R7
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !(mul_valid && (mul_dst == ld_sel)))
        |=> (rf_view[$past(ld_sel)] == $past(ld_word)));
    // R8
    mul_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && mul_valid && (mul_dst == ld_sel) && (ld_word != {hi_r, lo_r}))
        |=> (rf_view[$past(mul_dst)] != $past(ld_word)));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !mul_valid) |=> $stable(rf_view));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rf_view == '0));
endmodule

bind fhmul_unit fhmul_chk #(.NREG(NREG), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_sel   (ld_sel),
    .ld_word  (ld_word),
    .mul_valid(mul_valid),
    .mul_dst  (mul_dst),
    .hi_a     (opa_v[1]),
    .hi_b     (opb_v[1]),
    .hi_r     (lres[1]),
    .lo_a     (opa_v[0]),
    .lo_b     (opb_v[0]),
    .lo_r     (lres[0]),
    .rf_view  (rf_view)
);

// File: tb/sim_fhmul_unit.sv
// sim_fhmul_unit: directed bench for fhmul_unit, one task per scenario.
module sim_fhmul_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_en, mul_valid;
    logic [2:0]  ld_sel, mul_dst, rd_idx;
    logic [31:0] ld_word;
    logic [2:0]  hi_a_idx, hi_b_idx, lo_a_idx, lo_b_idx;
    logic        hi_a_upper, hi_b_upper, lo_a_upper, lo_b_upper;
    logic [31:0] rd_word;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl [8];

    localparam logic UP = 1'b1;
    localparam logic DN = 1'b0;

    always #10 clk = ~clk;

    fhmul_unit u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_word(ld_word), .mul_valid(mul_valid), .mul_dst(mul_dst),
        .hi_a_idx(hi_a_idx), .hi_a_upper(hi_a_upper),
        .hi_b_idx(hi_b_idx), .hi_b_upper(hi_b_upper),
        .lo_a_idx(lo_a_idx), .lo_a_upper(lo_a_upper),
        .lo_b_idx(lo_b_idx), .lo_b_upper(lo_b_upper),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    function automatic logic [15:0] frac(input logic [15:0] a, input logic [15:0] b);
        logic [31:0] p;
        p = {16'h0, a} * {16'h0, b};
        return p[31:16];
    endfunction

    function automatic logic [15:0] pick(input logic [3:0] s);
        return s[0] ? mdl[s[3:1]][31:16] : mdl[s[3:1]][15:0];
    endfunction

    function automatic logic [3:0] sel(input int idx, input logic up);
        return {idx[2:0], up};
    endfunction

    task automatic check(input int r, input logic [31:0] exp, input string tag);
        rd_idx = r[2:0];
        #1;
        n_chk++;
        if (rd_word !== exp) begin
            n_bad++;
            $display("FAIL %s reg %0d actual %h expected %h", tag, r, rd_word, exp);
        end
    endtask

    // one clock of stimulus: optional load and optional multiply, model updated
    task automatic issue(input logic do_ld, input int la, input logic [31:0] ld,
                         input logic do_mul, input int dst,
                         input logic [3:0] ha, input logic [3:0] hb,
                         input logic [3:0] lA, input logic [3:0] lB);
        logic [15:0] rh, rl;
        @(negedge clk);
        rh = frac(pick(ha), pick(hb));
        rl = frac(pick(lA), pick(lB));
        ld_en = do_ld; ld_sel = la[2:0]; ld_word = ld;
        mul_valid = do_mul; mul_dst = dst[2:0];
        {hi_a_idx, hi_a_upper} = ha; {hi_b_idx, hi_b_upper} = hb;
        {lo_a_idx, lo_a_upper} = lA; {lo_b_idx, lo_b_upper} = lB;
        if (do_ld) mdl[la] = ld;
        if (do_mul) mdl[dst] = {rh, rl};
        @(negedge clk);
        ld_en = 1'b0; mul_valid = 1'b0;
    endtask

    task automatic load(input int r, input logic [31:0] v);
        issue(1'b1, r, v, 1'b0, 0, 4'h0, 4'h0, 4'h0, 4'h0);
    endtask

    task automatic mul(input int dst, input logic [3:0] ha, input logic [3:0] hb,
                       input logic [3:0] lA, input logic [3:0] lB);
        issue(1'b0, 0, 32'h0, 1'b1, dst, ha, hb, lA, lB);
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    endtask

    task automatic t_reset();
        load(2, 32'hDEADBEEF);
        check(2, 32'hDEADBEEF, "R7 pre-reset load");
        apply_reset();
        for (int i = 0; i < 8; i++) check(i, 32'h0, "R9 reset clear");
    endtask

    task automatic t_load_read();
        for (int i = 0; i < 8; i++) load(i, 32'h1111_0000 * (i + 1) + i);
        for (int i = 7; i >= 0; i--) check(i, mdl[i], "R10 async read / R7 load");
    endtask

    task automatic t_trunc();
        load(0, 32'h8b235625);
        load(1, 32'h98ba5127);
        mul(4, sel(0, DN), sel(0, DN), sel(0, DN), sel(0, DN));
        check(4, 32'h1CFC1CFC, "R1 square low half");
        mul(5, sel(0, DN), sel(1, DN), sel(0, DN), sel(1, UP));
        check(5, 32'h1B4E3364, "R1 cross halves");
        mul(7, sel(1, DN), sel(1, DN), sel(1, UP), sel(1, UP));
        check(7, 32'h19B95B1D, "R1 upper squares");
    endtask

    task automatic t_unsigned();
        load(6, 32'h800ee06d);
        mul(0, sel(6, UP), sel(6, UP), sel(6, DN), sel(6, DN));
        check(0, 32'h400EC4BE, "R2 bit15 operands");
        load(2, 32'hFFFFFFFF);
        mul(3, sel(2, UP), sel(2, DN), sel(2, DN), sel(2, UP));
        check(3, 32'hFFFEFFFE, "R2 full-scale");
    endtask

    task automatic t_select();
        for (int i = 0; i < 8; i++) load(i, 32'h1324_8766 ^ (32'h0F1E_2D3C * (i + 3)));
        for (int k = 0; k < 8; k++) begin
            mul((k + 3) % 8, sel(k, UP), sel((k + 1) % 8, DN),
                sel((k + 5) % 8, DN), sel((k + 2) % 8, UP));
            check((k + 3) % 8, mdl[(k + 3) % 8], "R4 independent selection / R3 lane placement");
        end
        mul(1, sel(4, DN), sel(7, UP), sel(2, UP), sel(6, DN));
        check(1, mdl[1], "R3 lanes differ");
    endtask

    task automatic t_zero();
        load(1, 32'h000C0007);
        load(2, 32'h5A5A5A5A);
        mul(2, sel(1, UP), sel(1, DN), sel(1, DN), sel(1, DN));
        check(2, 32'h0, "R5 tiny products");
        load(3, 32'h0000FFFF);
        mul(4, sel(3, UP), sel(3, DN), sel(3, DN), sel(3, DN));
        check(4, 32'hFFFE_0000 & 32'h0000_FFFF | 32'h0000FFFE, "R5 zero operand high lane");
    endtask

    task automatic t_self();
        load(0, 32'h8b235625);
        load(1, 32'h98ba5127);
        mul(0, sel(0, DN), sel(0, DN), sel(0, DN), sel(0, DN));
        check(0, 32'h1CFC1CFC, "R6 own destination as source");
        mul(1, sel(0, DN), sel(1, DN), sel(0, DN), sel(1, UP));
        check(1, 32'h0930114A, "R6 next command sees update");
    endtask

    task automatic t_conflict();
        load(5, 32'h5625_98BA);
        issue(1'b1, 3, 32'hAAAA5555, 1'b1, 3, sel(5, UP), sel(5, UP), sel(5, DN), sel(5, DN));
        check(3, 32'h1CFC5B1D, "R8 multiply wins");
        issue(1'b1, 4, 32'hCAFEF00D, 1'b1, 6, sel(5, UP), sel(5, DN), sel(5, DN), sel(5, UP));
        check(4, 32'hCAFEF00D, "R7 load beside multiply");
        check(6, mdl[6], "R3 multiply beside load");
    endtask

    task automatic t_idle();
        hi_a_idx = 3'd5; hi_b_idx = 3'd5; lo_a_idx = 3'd5; lo_b_idx = 3'd5;
        ld_sel = 3'd5; ld_word = 32'h12345678; mul_dst = 3'd5;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) check(i, mdl[i], "R11 idle hold");
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; ld_en = 1'b0; mul_valid = 1'b0;
        ld_sel = '0; ld_word = '0; mul_dst = '0; rd_idx = '0;
        {hi_a_idx, hi_a_upper, hi_b_idx, hi_b_upper} = '0;
        {lo_a_idx, lo_a_upper, lo_b_idx, lo_b_upper} = '0;
        for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_read();
        t_trunc();
        t_unsigned();
        t_select();
        t_zero();
        t_self();
        t_conflict();
        t_idle();
        summary();
        $finish;
    end
endmodule